// File: doc/BRIEF.md
# Reset-Time Configuration Strap Capture and Decode

This block samples five configuration pins while the system is held in reset and keeps the sampled values as strap bits until power is removed. A pin that no external circuit drives takes the level of its weak pull, so an unconnected board still gives a defined configuration. Three reset sources can open the sampling window: power-on, watchdog and brownout. While any of them is asserted, the strap register follows the resolved pin levels on every clock. The value present on the last clock edge before the final reset source drops is the one that stays.

The held strap word is decoded into four results:
- a boot-mode choice, with a flag for a combination that is not allowed;
- an internal regulator voltage select;
- a boot-log enable;
- an SDIO slave edge-timing pair.

After boot, software may replace the regulator select and the edge timing through override registers. An override applies only while its valid bit is set, and any reset clears it. When reset is released, each strap pin gets a hand-back flag that returns it to its normal function.

All inputs and outputs are plain level signals. The block has no streamed data path, so there is no valid/ready handshake and no back-pressure.

Top module: `boot_strap_unit`

## Requirements
- R1: While any reset source is high, the strap word is reloaded from the resolved pins on every rising clock edge. The value captured on the last edge with reset high is held. Pin changes made while no reset is high leave `strap_word` unchanged.
- R2: Each of the power-on, watchdog and brownout reset inputs opens the sampling window on its own, and each sets `strap_valid`.
- R3: A pin whose `pin_drv` bit is 0 resolves to its pull default. Bit 0 (boot primary) defaults to 1, bit 1 (boot qualifier) to 0, bit 2 (regulator) to 0, bit 3 (log/timing high) to 1 and bit 4 (timing low) to 1.
- R4: `boot_download` is 1 only when strap bit 0 is 0 and strap bit 1 is 0. When bit 0 is 1, the outputs select flash boot whatever bit 1 holds.
- R5: When strap bit 0 is 0 and bit 1 is 1, `strap_err` is 1 and `boot_download` is 0, which selects flash boot. In every other case `strap_err` is 0.
- R6: With no override, `vsel_1v8` equals strap bit 2: 0 selects 3.3 V and 1 selects 1.8 V.
- R7: `bootlog_en` equals strap bit 3: 1 lets the boot log toggle the UART transmit line, 0 keeps it silent.
- R8: With no override, the timing code is {bit 3, bit 4}. `sdio_in_rise` is code bit 1 (1 = sample input on the rising edge, 0 = falling). `sdio_out_rise` is code bit 0 (1 = launch output on the rising edge, 0 = falling).
- R9: `pin_release` is all zeros while any reset is high or before any capture since power-down. Otherwise it is all ones.
- R10: A `cfg_we` pulse with no reset high loads the override registers. An override drives its output from the next cycle, but only if its valid bit is 1. Any reset or power-down clears both overrides.
- R11: `pwr_down` clears `strap_word` to 0 and `strap_valid` to 0, and it takes priority over the reset sources.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running clock |
| rst_por | input | 1 | Power-on reset, active high |
| rst_wdt | input | 1 | Watchdog reset, active high |
| rst_bor | input | 1 | Brownout reset, active high |
| pwr_down | input | 1 | Power removal, clears held straps |
| pin_lvl | input | 5 | Raw strap pin levels |
| pin_drv | input | 5 | 1 = pin driven externally, 0 = use weak pull |
| cfg_we | input | 1 | Override register write strobe |
| cfg_vsel_vld | input | 1 | Regulator override valid |
| cfg_vsel | input | 1 | Regulator override value (1 = 1.8 V) |
| cfg_sdio_vld | input | 1 | Timing override valid |
| cfg_sdio | input | 2 | Timing override code {in_rise, out_rise} |
| strap_word | output | 5 | Held strap bits, readable as status |
| strap_valid | output | 1 | A capture has happened since power-down |
| boot_download | output | 1 | 1 = download boot, 0 = flash boot |
| strap_err | output | 1 | Disallowed boot strap combination |
| vsel_1v8 | output | 1 | Effective regulator select |
| bootlog_en | output | 1 | Boot log output enable |
| sdio_in_rise | output | 1 | Effective input sampling edge |
| sdio_out_rise | output | 1 | Effective output launch edge |
| pin_release | output | 5 | Per-pin hand-back to normal function |

## Verification
The bench builds the block with its default pull vector. It drives pin patterns that mix driven and undriven pins, so every pull default shows up in the held word next to driven levels of the opposite value. Because that vector is kept at its default, the expected word follows directly from the bit defaults stated in R3. Each reset source is used alone, and pins are changed both inside the reset window and after it closes, which covers the last-value and hold rules. The overrides are written with their valid bits both set and clear, and a watchdog reset afterwards shows that they are dropped.

// File: rtl/strap_pkg.sv
package strap_pkg;
  localparam int STRAP_W  = 5;
  localparam int SDIO_W   = 2;
  localparam int IDX_BOOT = 0;
  localparam int IDX_QUAL = 1;
  localparam int IDX_VREG = 2;
  localparam int IDX_LOG  = 3;
  localparam int IDX_EDGE = 4;

  typedef enum logic [1:0] {
    BOOT_FLASH    = 2'd0,
    BOOT_DOWNLOAD = 2'd1,
    BOOT_BAD      = 2'd2
  } boot_sel_e;

  typedef struct packed {
    logic in_rise;
    logic out_rise;
  } sdio_edge_t;
endpackage

// File: rtl/strap_capture.sv
module strap_capture
  import strap_pkg::*;
#(
  parameter int           W     = STRAP_W,
  parameter logic [W-1:0] PULLS = 5'b11001
) (
  input  logic         clk,
  input  logic         pwr_down,
  input  logic         in_reset,
  input  logic [W-1:0] pin_lvl,
  input  logic [W-1:0] pin_drv,
  output logic [W-1:0] latch_q,
  output logic         valid_q
);
  logic [W-1:0] resolved;

  // Each pin takes its driven level, or its weak-pull default when undriven.
  for (genvar i = 0; i < W; i++) begin : g_pin
    assign resolved[i] = pin_drv[i] ? pin_lvl[i] : PULLS[i];
  end

  // Power-down wins over every reset source.
  always_ff @(posedge clk) begin
    if (pwr_down) begin
      latch_q <= '0;
      valid_q <= 1'b0;
    end else if (in_reset) begin
      latch_q <= resolved;
      valid_q <= 1'b1;
    end
  end

  // R1
  capture_track_chk: assert property (@(posedge clk) disable iff (pwr_down)
    in_reset |=> (latch_q == $past(resolved)));
  // R1
  hold_after_release_chk: assert property (@(posedge clk) disable iff (pwr_down)
    (!in_reset && !$past(in_reset) && !$past(pwr_down)) |-> $stable(latch_q));
  // R11
  powerdown_clear_chk: assert property (@(posedge clk)
    $past(pwr_down) |-> (latch_q == '0 && !valid_q));
endmodule

// File: rtl/strap_decode.sv
module strap_decode
  import strap_pkg::*;
#(
  parameter int W = STRAP_W
) (
  input  logic [W-1:0] latch_q,
  output boot_sel_e    boot_sel,
  output logic         vreg_strap,
  output logic         log_en,
  output sdio_edge_t   sdio_strap
);
  always_comb begin
    if (latch_q[IDX_BOOT])       boot_sel = BOOT_FLASH;
    else if (!latch_q[IDX_QUAL]) boot_sel = BOOT_DOWNLOAD;
    else                         boot_sel = BOOT_BAD;
  end

  assign vreg_strap          = latch_q[IDX_VREG];
  assign log_en              = latch_q[IDX_LOG];
  assign sdio_strap.in_rise  = latch_q[IDX_LOG];
  assign sdio_strap.out_rise = latch_q[IDX_EDGE];

  // R4
  always_comb primary_high_flash_chk: assert (!latch_q[IDX_BOOT] || boot_sel == BOOT_FLASH);
endmodule

// File: rtl/strap_override.sv
module strap_override
  import strap_pkg::*;
(
  input  logic       clk,
  input  logic       clr,
  input  logic       we,
  input  logic       vsel_vld,
  input  logic       vsel,
  input  logic       sdio_vld,
  input  sdio_edge_t sdio,
  input  logic       vreg_strap,
  input  sdio_edge_t sdio_strap,
  output logic       vreg_eff,
  output sdio_edge_t sdio_eff
);
  logic       vsel_vld_q;
  logic       vsel_q;
  logic       sdio_vld_q;
  sdio_edge_t sdio_q;

  always_ff @(posedge clk) begin
    if (clr) begin
      vsel_vld_q <= 1'b0;
      vsel_q     <= 1'b0;
      sdio_vld_q <= 1'b0;
      sdio_q     <= '0;
    end else if (we) begin
      vsel_vld_q <= vsel_vld;
      vsel_q     <= vsel;
      sdio_vld_q <= sdio_vld;
      sdio_q     <= sdio;
    end
  end

  assign vreg_eff = vsel_vld_q ? vsel_q : vreg_strap;
  assign sdio_eff = sdio_vld_q ? sdio_q : sdio_strap;

  // R10
  override_cleared_chk: assert property (@(posedge clk)
    $past(clr) |-> (!vsel_vld_q && !sdio_vld_q));
endmodule

// File: rtl/boot_strap_unit.sv
module boot_strap_unit
  import strap_pkg::*;
#(
  parameter int               W     = STRAP_W,
  parameter int               SW    = SDIO_W,
  parameter logic [W-1:0]     PULLS = 5'b11001
) (
  input  logic          clk,
  input  logic          rst_por,
  input  logic          rst_wdt,
  input  logic          rst_bor,
  input  logic          pwr_down,
  input  logic [W-1:0]  pin_lvl,
  input  logic [W-1:0]  pin_drv,
  input  logic          cfg_we,
  input  logic          cfg_vsel_vld,
  input  logic          cfg_vsel,
  input  logic          cfg_sdio_vld,
  input  logic [SW-1:0] cfg_sdio,
  output logic [W-1:0]  strap_word,
  output logic          strap_valid,
  output logic          boot_download,
  output logic          strap_err,
  output logic          vsel_1v8,
  output logic          bootlog_en,
  output logic          sdio_in_rise,
  output logic          sdio_out_rise,
  output logic [W-1:0]  pin_release
);
  logic       in_reset;
  logic [W-1:0] latch_q;
  logic       valid_q;
  boot_sel_e  boot_sel;
  logic       vreg_strap;
  logic       log_en;
  sdio_edge_t sdio_strap;
  sdio_edge_t sdio_eff;
  sdio_edge_t cfg_sdio_s;

  assign in_reset   = rst_por | rst_wdt | rst_bor;
  assign cfg_sdio_s = sdio_edge_t'(cfg_sdio);

  strap_capture #(.W(W), .PULLS(PULLS)) u_capture (
    .clk      (clk),
    .pwr_down (pwr_down),
    .in_reset (in_reset),
    .pin_lvl  (pin_lvl),
    .pin_drv  (pin_drv),
    .latch_q  (latch_q),
    .valid_q  (valid_q)
  );

  strap_decode #(.W(W)) u_decode (
    .latch_q    (latch_q),
    .boot_sel   (boot_sel),
    .vreg_strap (vreg_strap),
    .log_en     (log_en),
    .sdio_strap (sdio_strap)
  );

  strap_override u_override (
    .clk        (clk),
    .clr        (in_reset | pwr_down),
    .we         (cfg_we),
    .vsel_vld   (cfg_vsel_vld),
    .vsel       (cfg_vsel),
    .sdio_vld   (cfg_sdio_vld),
    .sdio       (cfg_sdio_s),
    .vreg_strap (vreg_strap),
    .sdio_strap (sdio_strap),
    .vreg_eff   (vsel_1v8),
    .sdio_eff   (sdio_eff)
  );

  assign strap_word    = latch_q;
  assign strap_valid   = valid_q;
  assign boot_download = (boot_sel == BOOT_DOWNLOAD);
  assign strap_err     = (boot_sel == BOOT_BAD);
  assign bootlog_en    = log_en;
  assign sdio_in_rise  = sdio_eff.in_rise;
  assign sdio_out_rise = sdio_eff.out_rise;

  // Hand each strap pin back once reset is gone and a capture exists.
  for (genvar i = 0; i < W; i++) begin : g_release
    assign pin_release[i] = valid_q & ~in_reset;
  end

  // R5
  bad_strap_no_download_chk: assert property (@(posedge clk) disable iff (pwr_down)
    strap_err |-> !boot_download);
  // R9
  release_needs_capture_chk: assert property (@(posedge clk) disable iff (pwr_down)
    (pin_release != '0) |-> (strap_valid && !rst_por && !rst_wdt && !rst_bor));
  // R2
  reset_sets_valid_chk: assert property (@(posedge clk) disable iff (pwr_down)
    (rst_por || rst_wdt || rst_bor) |=> strap_valid);
endmodule

// File: tb/test_boot_strap_unit.sv
module test_boot_strap_unit;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_por = 0, rst_wdt = 0, rst_bor = 0, pwr_down = 1;
  logic [4:0] pin_lvl = 0, pin_drv = 0;
  logic       cfg_we = 0, cfg_vsel_vld = 0, cfg_vsel = 0, cfg_sdio_vld = 0;
  logic [1:0] cfg_sdio = 0;
  logic [4:0] strap_word, pin_release;
  logic       strap_valid, boot_download, strap_err, vsel_1v8, bootlog_en;
  logic       sdio_in_rise, sdio_out_rise;

  int checks = 0, errors = 0;
  logic [4:0] exp_q[$];
  localparam logic [4:0] PULL_DEF = 5'b11001;

  boot_strap_unit i_boot_strap_unit (.*);

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  function automatic logic [4:0] resolve(input logic [4:0] lvl, input logic [4:0] drv);
    for (int i = 0; i < 5; i++) resolve[i] = drv[i] ? lvl[i] : PULL_DEF[i];
  endfunction

  // Monitor: pops expected strap words and compares all decoded outputs.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [4:0] w;
      w = exp_q.pop_front();
      check("R1 R3 word", {3'b0, strap_word}, {3'b0, w});
      check("R2 valid", {7'b0, strap_valid}, 8'd1);
      check("R4 download", {7'b0, boot_download}, {7'b0, (!w[0] && !w[1])});
      check("R5 err", {7'b0, strap_err}, {7'b0, (!w[0] && w[1])});
      check("R6 vsel", {7'b0, vsel_1v8}, {7'b0, w[2]});
      check("R7 log", {7'b0, bootlog_en}, {7'b0, w[3]});
      check("R8 sdio", {6'b0, sdio_in_rise, sdio_out_rise}, {6'b0, w[3], w[4]});
      check("R9 release", {3'b0, pin_release}, 8'h1f);
    end
  end

  // Driver: open a window on one source, change pins inside it, close, disturb pins.
  task automatic strap_cycle(input logic [4:0] lvl, input logic [4:0] drv, input int src);
    @(negedge clk);
    pin_lvl = ~lvl; pin_drv = 5'h1f;
    case (src)
      0: rst_por = 1;
      1: rst_wdt = 1;
      default: rst_bor = 1;
    endcase
    @(negedge clk);
    check("R9 release in reset", {3'b0, pin_release}, 8'h00);
    pin_lvl = lvl; pin_drv = drv;
    @(negedge clk);
    rst_por = 0; rst_wdt = 0; rst_bor = 0;
    pin_lvl = ~lvl; pin_drv = 5'h1f;
    exp_q.push_back(resolve(lvl, drv));
    repeat (3) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    pwr_down = 0;
    @(negedge clk);
    // R11 reset state after power-down
    check("R11 word", {3'b0, strap_word}, 8'h00);
    check("R11 valid", {7'b0, strap_valid}, 8'h00);
    check("R9 no capture", {3'b0, pin_release}, 8'h00);

    strap_cycle(5'b00000, 5'b00000, 0);  // R3 all pulls
    strap_cycle(5'b00000, 5'b11111, 1);  // R4 download, 3.3V, silent, 00
    strap_cycle(5'b00010, 5'b00011, 2);  // R5 invalid combo
    strap_cycle(5'b10101, 5'b11111, 0);  // R6 1.8V, flash, 01
    strap_cycle(5'b01001, 5'b11111, 1);  // R8 code 10
    strap_cycle(5'b00110, 5'b00110, 2);  // R3 mixed driven/pulled

    // R10 override with valid bits set
    strap_cycle(5'b00000, 5'b11111, 0);
    @(negedge clk);
    cfg_we = 1; cfg_vsel_vld = 1; cfg_vsel = 1; cfg_sdio_vld = 1; cfg_sdio = 2'b11;
    @(negedge clk);
    cfg_we = 0;
    check("R10 vsel override", {7'b0, vsel_1v8}, 8'd1);
    check("R10 sdio override", {6'b0, sdio_in_rise, sdio_out_rise}, 8'd3);
    // R10 writes with valid clear have no effect
    cfg_we = 1; cfg_vsel_vld = 0; cfg_vsel = 1; cfg_sdio_vld = 0; cfg_sdio = 2'b11;
    @(negedge clk);
    cfg_we = 0;
    check("R10 vsel no valid", {7'b0, vsel_1v8}, 8'd0);
    check("R10 sdio no valid", {6'b0, sdio_in_rise, sdio_out_rise}, 8'd0);
    // R10 reset clears override
    cfg_we = 1; cfg_vsel_vld = 1; cfg_vsel = 1; cfg_sdio_vld = 1; cfg_sdio = 2'b11;
    @(negedge clk);
    cfg_we = 0;
    strap_cycle(5'b00000, 5'b11111, 1);
    check("R10 cleared vsel", {7'b0, vsel_1v8}, 8'd0);
    check("R10 cleared sdio", {6'b0, sdio_in_rise, sdio_out_rise}, 8'd0);

    // R1 pins moving after release leave the word alone
    pin_lvl = 5'h1f; pin_drv = 5'h1f;
    repeat (2) @(negedge clk);
    check("R1 hold", {3'b0, strap_word}, 8'h00);

    // R11 power-down beats a concurrent reset
    rst_por = 1; pwr_down = 1;
    @(negedge clk);
    rst_por = 0; pwr_down = 0;
    @(negedge clk);
    check("R11 pd word", {3'b0, strap_word}, 8'h00);
    check("R11 pd valid", {7'b0, strap_valid}, 8'h00);
    check("R9 pd release", {3'b0, pin_release}, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule